// File: doc/BRIEF.md
# Infrared Link Line Status Collector

This block gathers the receive and transmit conditions of an infrared serial link controller into one 8-bit read-only status byte. Four of its bits are sticky event flags: bad CRC, physical-layer error, frame too long and last byte of a frame popped by the host. A host read of the status byte clears them. The other bits show live conditions: the transmitter is drained, and the receive FIFO is empty.

The physical-layer error depends on the link mode. In the slow-synchronous mode (MIR), the block watches the decoded bit stream and flags an abort pattern: more than seven consecutive ones. In the fast mode (FIR), it takes an illegal-symbol strobe from the 4PPM decoder. A byte counter checks each accepted byte against a programmable 16-bit maximum frame length, given as a low and a high byte. When a frame runs past that length, the block drops a receive-enable gate. The gate stays low until the next begin-of-frame strobe, and in the meantime no bytes are counted.

Top module: `irda_line_status`

## Requirements
- R1: With both transmit conditions and the receive-empty flag high after reset, the status byte reads 0x83, with bits 5 down to 2 at 0.
- R2: Bit 7 is the AND of `tx_fifo_empty` and `tx_idle` in the same cycle, with no register in the path.
- R3: Bit 0 follows `rx_fifo_empty` in the same cycle and is not sticky. Bit 6 always reads 0 and bit 1 always reads 1.
- R4: The byte counter clears on `bof`. A byte is accepted when `rx_byte_valid` is high, the gate is open and `bof` is low. An accepted byte that finds the count already equal to {`max_len_hi`,`max_len_lo`} sets bit 4 from the next cycle on. Below that count it only increments.
- R5: `rx_enable` is 1 after reset. It drops in the cycle after an overrun and stays low, with bytes ignored, until the cycle after a `bof` strobe.
- R6: With `mode_mir` high, the eighth consecutive valid 1 bit in `mir_bit` sets bit 3. A valid 0 bit, a `bof` strobe or FIR mode restarts the run, and a run that keeps going yields no further event.
- R7: With `mode_mir` low, `ppm_illegal` sets bit 3. With `mode_mir` high, `ppm_illegal` has no effect.
- R8: `crc_bad` sets bit 2 and `rx_pop_last` sets bit 5, each visible from the cycle after the strobe.
- R9: Bits 5 to 2 hold until a cycle with `lsr_rd` high. That cycle still shows the old value, and the flags clear at its closing edge.
- R10: When a flag's set event and `lsr_rd` share a cycle, the flag stays set after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_mir | input | 1 | 1 selects MIR run detection, 0 selects FIR illegal-symbol input |
| crc_bad | input | 1 | Bad CRC strobe from the receiver |
| ppm_illegal | input | 1 | Illegal 4PPM symbol strobe |
| mir_bit_valid | input | 1 | Qualifies `mir_bit` |
| mir_bit | input | 1 | Decoded MIR data bit |
| bof | input | 1 | Begin-of-frame strobe |
| rx_byte_valid | input | 1 | Receiver offers one byte |
| max_len_lo | input | 8 | Low byte of the maximum frame length |
| max_len_hi | input | 8 | High byte of the maximum frame length |
| rx_pop_last | input | 1 | Host popped the final byte of a frame |
| rx_fifo_empty | input | 1 | Receive FIFO empty |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_idle | input | 1 | Transmit front end idle |
| lsr_rd | input | 1 | Host read strobe for the status byte |
| lsr_data | output | 8 | Status byte |
| rx_enable | output | 1 | Receive gate, low after an overrun |

## Verification
Bits 7, 6, 1 and 0 have no register in their path, so they are due in the same cycle as their inputs. The sticky bits 5 to 2 and `rx_enable` are due one edge after the strobe or read that moves them. The bench changes inputs on the falling edge and compares all outputs shortly after it. That sample shows the combinational bits for the fresh inputs and the registered bits from the rising edge before. Only after that comparison does the bench advance its own model of the flags, run counter, byte counter and gate, so each expected value matches the edge the design has actually seen.

// File: rtl/irlsr_pkg.sv
package irlsr_pkg;

  typedef struct packed {
    logic last;
    logic len;
    logic phy;
    logic crc;
  } lsr_flags_t;

  localparam int FLAG_N = $bits(lsr_flags_t);

  // Status byte layout: [7] tx drained, [6] 0, [5:2] sticky flags, [1] 1, [0] rx empty
  function automatic logic [7:0] pack_lsr(input logic tx_drained,
                                          input lsr_flags_t fl,
                                          input logic rx_empty);
    return {tx_drained, 1'b0, fl.last, fl.len, fl.phy, fl.crc, 1'b1, rx_empty};
  endfunction

endpackage

// File: rtl/irlsr_mir_abort.sv
module irlsr_mir_abort #(
  parameter int RUN_LIMIT = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_mir_i,
  input  logic bof_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic abort_o
);
  localparam int CW = $clog2(RUN_LIMIT + 2);
  localparam logic [CW-1:0] LIMIT_C = CW'(RUN_LIMIT);
  localparam logic [CW-1:0] SAT_C   = CW'(RUN_LIMIT + 1);

  logic [CW-1:0] run_q;
  logic          restart;
  logic          one_seen;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] r);
    return (r == SAT_C) ? r : r + 1'b1;
  endfunction

  assign restart  = bof_i | ~mode_mir_i;
  assign one_seen = bit_vld_i & bit_i;
  assign abort_o  = ~restart & one_seen & (run_q == LIMIT_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (restart) begin
      run_q <= '0;
    end else if (bit_vld_i) begin
      run_q <= bit_i ? bump(run_q) : '0;
    end
  end
endmodule

// File: rtl/irlsr_len_guard.sv
module irlsr_len_guard #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bof_i,
  input  logic             byte_vld_i,
  input  logic [LEN_W-1:0] max_len_i,
  output logic             rx_en_o,
  output logic             overrun_o
);
  logic [LEN_W-1:0] cnt_q;
  logic             en_q;
  logic             accept;

  function automatic logic beyond_max(input logic [LEN_W-1:0] c,
                                      input logic [LEN_W-1:0] m);
    logic [LEN_W:0] nxt;
    nxt = {1'b0, c} + 1'b1;
    return nxt > {1'b0, m};
  endfunction

  assign accept    = byte_vld_i & en_q & ~bof_i;
  assign overrun_o = accept & beyond_max(cnt_q, max_len_i);
  assign rx_en_o   = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b1;
    end else if (bof_i) begin
      cnt_q <= '0;
      en_q  <= 1'b1;
    end else if (accept) begin
      if (overrun_o) en_q  <= 1'b0;
      else           cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/irlsr_sticky.sv
module irlsr_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i)    q <= 1'b0;
    end
    assign q_o[i] = q;
  end
endmodule

// File: rtl/irda_line_status.sv
module irda_line_status #(
  parameter int LEN_W     = 16,
  parameter int RUN_LIMIT = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_mir,
  input  logic       crc_bad,
  input  logic       ppm_illegal,
  input  logic       mir_bit_valid,
  input  logic       mir_bit,
  input  logic       bof,
  input  logic       rx_byte_valid,
  input  logic [7:0] max_len_lo,
  input  logic [7:0] max_len_hi,
  input  logic       rx_pop_last,
  input  logic       rx_fifo_empty,
  input  logic       tx_fifo_empty,
  input  logic       tx_idle,
  input  logic       lsr_rd,
  output logic [7:0] lsr_data,
  output logic       rx_enable
);
  import irlsr_pkg::*;

  logic [LEN_W-1:0] max_len;
  logic             mir_abort;
  logic             len_overrun;
  logic             phy_event;
  lsr_flags_t       set_vec;
  lsr_flags_t       flags;

  assign max_len = LEN_W'({max_len_hi, max_len_lo});

  irlsr_mir_abort #(.RUN_LIMIT(RUN_LIMIT)) u_mir (
    .clk(clk), .rst_n(rst_n), .mode_mir_i(mode_mir), .bof_i(bof),
    .bit_vld_i(mir_bit_valid), .bit_i(mir_bit), .abort_o(mir_abort)
  );

  irlsr_len_guard #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .bof_i(bof), .byte_vld_i(rx_byte_valid),
    .max_len_i(max_len), .rx_en_o(rx_enable), .overrun_o(len_overrun)
  );

  assign phy_event    = mode_mir ? mir_abort : ppm_illegal;
  assign set_vec.last = rx_pop_last;
  assign set_vec.len  = len_overrun;
  assign set_vec.phy  = phy_event;
  assign set_vec.crc  = crc_bad;

  irlsr_sticky #(.N(FLAG_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(lsr_rd), .q_o(flags)
  );

  assign lsr_data = pack_lsr(tx_fifo_empty & tx_idle, flags, rx_fifo_empty);
endmodule

// File: rtl/irlsr_checker.sv
module irlsr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       lsr_rd,
  input logic       crc_bad,
  input logic       bof,
  input logic       rx_enable,
  input logic [7:0] lsr_data,
  input logic       len_overrun,
  input logic       mir_abort
);
  assert_len_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    len_overrun |=> lsr_data[4]);

  assert_gate_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (len_overrun && !bof) |=> !rx_enable);

  assert_gate_reopens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bof |=> rx_enable);

  assert_abort_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mir_abort |=> !mir_abort);

  assert_crc_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    crc_bad |=> lsr_data[2]);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_data[2] && !lsr_rd) |=> lsr_data[2]);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !crc_bad) |=> !lsr_data[2]);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && crc_bad) |=> lsr_data[2]);
endmodule

bind irda_line_status irlsr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .lsr_rd(lsr_rd), .crc_bad(crc_bad), .bof(bof),
  .rx_enable(rx_enable), .lsr_data(lsr_data), .len_overrun(len_overrun),
  .mir_abort(mir_abort)
);

// File: tb/irda_line_status_tb.sv
module irda_line_status_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_mir = 1'b0, crc_bad = 1'b0, ppm_illegal = 1'b0;
  logic mir_bit_valid = 1'b0, mir_bit = 1'b0, bof = 1'b0, rx_byte_valid = 1'b0;
  logic [7:0] max_len_lo = 8'd0, max_len_hi = 8'd0;
  logic rx_pop_last = 1'b0, rx_fifo_empty = 1'b1, tx_fifo_empty = 1'b1, tx_idle = 1'b1;
  logic lsr_rd = 1'b0;
  logic [7:0] lsr_data;
  logic rx_enable;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  bit m_crc = 0, m_phy = 0, m_len = 0, m_last = 0, m_en = 1;
  int m_run = 0;
  int m_cnt = 0;

  always #10 clk = ~clk;

  irda_line_status u_dut (
    .clk(clk), .rst_n(rst_n), .mode_mir(mode_mir), .crc_bad(crc_bad),
    .ppm_illegal(ppm_illegal), .mir_bit_valid(mir_bit_valid), .mir_bit(mir_bit),
    .bof(bof), .rx_byte_valid(rx_byte_valid), .max_len_lo(max_len_lo),
    .max_len_hi(max_len_hi), .rx_pop_last(rx_pop_last), .rx_fifo_empty(rx_fifo_empty),
    .tx_fifo_empty(tx_fifo_empty), .tx_idle(tx_idle), .lsr_rd(lsr_rd),
    .lsr_data(lsr_data), .rx_enable(rx_enable)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit too_long(input int cnt, input int lim);
    return cnt >= lim;
  endfunction

  function automatic bit run_hits(input int run_before);
    return run_before == 7;
  endfunction

  // At a falling edge with inputs set: compare, advance model, wait next falling edge.
  task automatic cycle();
    bit acc;
    int lim;
    #1;
    chk("R2 bit7", {7'd0, lsr_data[7]}, {7'd0, tx_fifo_empty && tx_idle});
    chk("R3 bits6,1,0", {5'd0, lsr_data[6], lsr_data[1], lsr_data[0]},
        {5'd0, 1'b0, 1'b1, rx_fifo_empty});
    chk("R8 bit5", {7'd0, lsr_data[5]}, {7'd0, m_last});
    chk("R4 bit4", {7'd0, lsr_data[4]}, {7'd0, m_len});
    chk("R6 R7 bit3", {7'd0, lsr_data[3]}, {7'd0, m_phy});
    chk("R8 bit2", {7'd0, lsr_data[2]}, {7'd0, m_crc});
    chk("R5 rx_enable", {7'd0, rx_enable}, {7'd0, m_en});
    // clear on read first, events override (R9, R10)
    if (lsr_rd) begin m_crc = 0; m_phy = 0; m_len = 0; m_last = 0; end
    if (crc_bad) m_crc = 1;
    if (rx_pop_last) m_last = 1;
    if (!mode_mir && ppm_illegal) m_phy = 1;
    if (bof || !mode_mir) m_run = 0;
    else if (mir_bit_valid) begin
      if (!mir_bit) m_run = 0;
      else begin
        if (run_hits(m_run)) m_phy = 1;
        if (m_run < 100) m_run++;
      end
    end
    lim = {max_len_hi, max_len_lo};
    acc = rx_byte_valid && m_en && !bof;
    if (bof) begin m_cnt = 0; m_en = 1; end
    else if (acc) begin
      if (too_long(m_cnt, lim)) begin m_en = 0; m_len = 1; end
      else m_cnt++;
    end
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    crc_bad = 0; ppm_illegal = 0; mir_bit_valid = 0; mir_bit = 0; bof = 0;
    rx_byte_valid = 0; rx_pop_last = 0; lsr_rd = 0;
  endtask

  initial begin
    void'($urandom(32'h1A5C0DE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset value", lsr_data, 8'h83);
    chk("R1 reset gate", {7'd0, rx_enable}, 8'h01);
    @(negedge clk);

    // R10: crc set and read in one cycle
    idle_inputs(); crc_bad = 1; lsr_rd = 1; cycle();
    idle_inputs(); #1; chk("R10 set wins", {7'd0, lsr_data[2]}, 8'h01);
    lsr_rd = 1; cycle();   // R9: this read sees the flag
    idle_inputs(); #1; chk("R9 cleared after read", {4'd0, lsr_data[5:2]}, 8'h00);

    // R6: MIR run of exactly 7 ones, zero, then 8 ones
    mode_mir = 1;
    for (int i = 0; i < 7; i++) begin idle_inputs(); mir_bit_valid = 1; mir_bit = 1; cycle(); end
    idle_inputs(); mir_bit_valid = 1; mir_bit = 0; cycle();
    idle_inputs(); #1; chk("R6 seven ones no abort", {7'd0, lsr_data[3]}, 8'h00);
    for (int i = 0; i < 12; i++) begin idle_inputs(); mir_bit_valid = 1; mir_bit = 1; cycle(); end
    idle_inputs(); #1; chk("R6 eighth one aborts", {7'd0, lsr_data[3]}, 8'h01);
    lsr_rd = 1; cycle(); idle_inputs();
    ppm_illegal = 1; cycle(); idle_inputs();
    #1; chk("R7 ppm ignored in MIR", {7'd0, lsr_data[3]}, 8'h00);
    mode_mir = 0; ppm_illegal = 1; cycle(); idle_inputs();
    #1; chk("R7 ppm in FIR", {7'd0, lsr_data[3]}, 8'h01);
    lsr_rd = 1; cycle(); idle_inputs();

    // R4/R5: zero maximum, then a 16-bit maximum that needs the high byte
    max_len_hi = 0; max_len_lo = 0; bof = 1; cycle(); idle_inputs();
    rx_byte_valid = 1; cycle(); idle_inputs();
    #1; chk("R5 gate closed on first byte", {7'd0, rx_enable}, 8'h00);
    max_len_hi = 8'h01; max_len_lo = 8'h02; bof = 1; lsr_rd = 1; cycle(); idle_inputs();
    for (int i = 0; i < 258; i++) begin rx_byte_valid = 1; cycle(); end
    idle_inputs(); #1; chk("R4 at limit no flag", {7'd0, lsr_data[4]}, 8'h00);
    rx_byte_valid = 1; cycle(); idle_inputs();
    #1; chk("R4 past limit flag", {7'd0, lsr_data[4]}, 8'h01);
    for (int i = 0; i < 5; i++) begin rx_byte_valid = 1; cycle(); end
    idle_inputs(); bof = 1; cycle(); idle_inputs();
    #1; chk("R5 reopened by bof", {7'd0, rx_enable}, 8'h01);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      idle_inputs();
      if (($urandom % 200) == 0) mode_mir = ~mode_mir;
      if (($urandom % 300) == 0) begin max_len_hi = 0; max_len_lo = 8'($urandom % 6); end
      crc_bad       = (($urandom % 16) == 0);
      ppm_illegal   = (($urandom % 16) == 0);
      mir_bit_valid = (($urandom % 2) == 0);
      mir_bit       = (($urandom % 10) != 0);
      bof           = (($urandom % 25) == 0);
      rx_byte_valid = (($urandom % 2) == 0);
      rx_pop_last   = (($urandom % 20) == 0);
      lsr_rd        = (($urandom % 6) == 0);
      rx_fifo_empty = 1'($urandom);
      tx_fifo_empty = 1'($urandom);
      tx_idle       = 1'($urandom);
      cycle();
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule